// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects thirty-two peripheral request lines and decides which one, if any, is offered to the processor core. Every line carries its own two-bit urgency level, an enable bit and a pending bit. A pending bit is armed either by a rising edge on its line or by a software write, so a line that is the OR of several peripheral flags raises one event when it first goes high and none while it stays high. The winner is presented as a vector number together with its level. The core takes it with an acknowledge strobe and later closes it with an end-of-service strobe.

A global threshold can hide all requests that are not more urgent than a chosen level. An in-service level register blocks everything that does not strictly beat the interrupt being served. One level of preemption is kept: a more urgent request may interrupt the current one, and on end of service the earlier level comes back. All control state sits behind a small single-cycle write port with a combinational read-back.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A 0-to-1 change on `irqLines[i]`, sampled on the clock, sets pending bit i. A line that stays high raises no further event once its pending bit has been cleared.
- R2: A write to address 1 sets pending bit i for every 1 in bit i of the write data. Zero bits leave pending unchanged. Reading address 1 returns the pending bits.
- R3: `ackStrobe` while `irqValid` is high clears the pending bit of the presented vector and makes its level the in-service level. If the same line has a rising edge in that cycle, its pending bit stays set.
- R4: A source can be presented only while both its enable bit and its pending bit are set. Among the eligible sources, the lowest numeric level wins (0 is most urgent). On a tie, the lowest index wins.
- R5: Address 2 holds the threshold: bit 2 switches it on, and bits 1:0 hold the threshold level. While it is on, only sources whose level is numerically below the threshold are presented.
- R6: While an interrupt is in service, only sources whose level is numerically below the in-service level are presented.
- R7: At most two levels can be in service. While two are in service, nothing is presented. `ackStrobe` while `irqValid` is low has no effect.
- R8: `eosStrobe` ends the current service and restores the preempted level, or the idle state if there was none. `eosStrobe` with nothing in service has no effect. If `eosStrobe` and an accepted acknowledge fall in the same cycle, the acknowledged level replaces the current one, and any preempted level stays saved.
- R9: After reset, every enable bit, pending bit, threshold field and in-service state is clear, every level is 0, and `irqValid` is low.
- R10: Address 0 reads and writes the enable bits. Address 3 holds the levels of sources 0 to 15, and address 4 holds those of sources 16 to 31: source i uses bits 2(i mod 16)+1 down to 2(i mod 16). Reads from any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| irqLines | input | 32 | Peripheral request lines |
| regWe | input | 1 | Register write enable |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` (combinational) |
| irqValid | output | 1 | A request is being presented |
| irqVector | output | 5 | Index of the presented source |
| irqLevel | output | 2 | Level of the presented source |
| ackStrobe | input | 1 | Core accepts the presented request |
| eosStrobe | input | 1 | Core finishes the current service |

## Verification
Two events can collide in one cycle. First, an acknowledge can clear a pending bit while a new rising edge or a software write sets that same bit. Second, an end-of-service can pop the in-service level while an acknowledge pushes a new one. Directed steps provoke both: one drops a line, then raises it in the very cycle its vector is acknowledged, and the pending bit is read back. Others send end-of-service together with an acknowledge, or with nothing in service. Random traffic then mixes edges, writes and both strobes on every cycle. A bench model built from the requirements judges the presented vector, its level and the read-back data after each edge.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;

  // register addresses
  localparam int ADDR_EN    = 0;
  localparam int ADDR_PEND  = 1;
  localparam int ADDR_MASK  = 2;
  localparam int ADDR_PRIO0 = 3;

  localparam int STROBE_IDX_W = 4;

  // control -> datapath strobes
  typedef struct packed {
    logic                    enWr;
    logic                    swSet;
    logic                    maskWr;
    logic                    prioWr;
    logic [STROBE_IDX_W-1:0] prioWord;
    logic                    ackTake;
    logic                    eosTake;
  } ctlStrobe_t;

endpackage

// File: rtl/prio_irq_ctl.sv
`timescale 1ns/1ps
module prio_irq_ctl
  import prio_irq_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int PRIO_W     = 2,
  parameter int PRIO_WORDS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              ackStrobe,
  input  logic              eosStrobe,
  input  logic              winValid,
  input  logic [PRIO_W-1:0] winLevel,
  output ctlStrobe_t        strobe,
  output logic              actValid,
  output logic [PRIO_W-1:0] actLevel,
  output logic              nestFull
);

  logic              savValid;
  logic [PRIO_W-1:0] savLevel;
  int                addrInt;

  // register decode and event qualification
  always_comb begin
    addrInt         = int'(regAddr);
    strobe          = '0;
    strobe.enWr     = regWe && (addrInt == ADDR_EN);
    strobe.swSet    = regWe && (addrInt == ADDR_PEND);
    strobe.maskWr   = regWe && (addrInt == ADDR_MASK);
    strobe.prioWr   = regWe && (addrInt >= ADDR_PRIO0) &&
                      (addrInt < ADDR_PRIO0 + PRIO_WORDS);
    strobe.prioWord = STROBE_IDX_W'(addrInt - ADDR_PRIO0);
    strobe.ackTake  = ackStrobe && winValid;
    strobe.eosTake  = eosStrobe && actValid;
  end

  // one-deep in-service stack
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actValid <= 1'b0;
      actLevel <= '0;
      savValid <= 1'b0;
      savLevel <= '0;
    end else if (strobe.ackTake && strobe.eosTake) begin
      actLevel <= winLevel;
    end else if (strobe.ackTake) begin
      if (actValid) begin
        savValid <= 1'b1;
        savLevel <= actLevel;
      end
      actValid <= 1'b1;
      actLevel <= winLevel;
    end else if (strobe.eosTake) begin
      actValid <= savValid;
      actLevel <= savLevel;
      savValid <= 1'b0;
      savLevel <= '0;
    end
  end

  assign nestFull = actValid && savValid;

endmodule

// File: rtl/prio_irq_dp.sv
`timescale 1ns/1ps
module prio_irq_dp
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC    = 32,
  parameter int PRIO_W     = 2,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  parameter int VEC_W      = 5,
  parameter int PRIO_WORDS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqLines,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  input  ctlStrobe_t         strobe,
  input  logic               actValid,
  input  logic [PRIO_W-1:0]  actLevel,
  input  logic               nestFull,
  output logic [DATA_W-1:0]  regRdata,
  output logic               winValid,
  output logic [VEC_W-1:0]   winVector,
  output logic [PRIO_W-1:0]  winLevel
);

  localparam int LEVELS   = 1 << PRIO_W;
  localparam int PER_WORD = DATA_W / PRIO_W;

  logic [NUM_SRC-1:0] enReg, pendReg, pendNext, prevLines, riseVec, cand;
  logic [PRIO_W-1:0]  prioReg [NUM_SRC];
  logic               maskOn;
  logic [PRIO_W-1:0]  maskLvl;
  logic [LEVELS-1:0][NUM_SRC-1:0] lvlHit;
  logic [PRIO_WORDS-1:0][DATA_W-1:0] prioPack;

  function automatic logic [VEC_W-1:0] lowestIdx(input logic [NUM_SRC-1:0] v);
    lowestIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (v[i]) lowestIdx = VEC_W'(i);
  endfunction

  assign riseVec = irqLines & ~prevLines;

  always_comb begin
    pendNext = pendReg;
    if (strobe.ackTake) pendNext[winVector] = 1'b0;
    pendNext = pendNext | riseVec;
    if (strobe.swSet) pendNext = pendNext | regWdata[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= '0;
      pendReg   <= '0;
      prevLines <= '0;
      maskOn    <= 1'b0;
      maskLvl   <= '0;
    end else begin
      prevLines <= irqLines;
      pendReg   <= pendNext;
      if (strobe.enWr) enReg <= regWdata[NUM_SRC-1:0];
      if (strobe.maskWr) begin
        maskOn  <= regWdata[PRIO_W];
        maskLvl <= regWdata[PRIO_W-1:0];
      end
    end
  end

  // per-source level storage and eligibility
  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    localparam int WORD = i / PER_WORD;
    localparam int SLOT = i % PER_WORD;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        prioReg[i] <= '0;
      else if (strobe.prioWr && (int'(strobe.prioWord) == WORD))
        prioReg[i] <= regWdata[SLOT*PRIO_W +: PRIO_W];
    end

    logic passMask, passAct;
    assign passMask = !maskOn || (prioReg[i] < maskLvl);
    assign passAct  = !actValid || (prioReg[i] < actLevel);
    assign cand[i]  = enReg[i] && pendReg[i] && passMask && passAct && !nestFull;
  end

  // arbitration: most urgent level first, lowest index within it
  always_comb begin
    for (int l = 0; l < LEVELS; l++)
      for (int i = 0; i < NUM_SRC; i++)
        lvlHit[l][i] = cand[i] && (prioReg[i] == PRIO_W'(l));
  end

  always_comb begin
    winValid  = 1'b0;
    winVector = '0;
    winLevel  = '0;
    for (int l = LEVELS - 1; l >= 0; l--) begin
      if (|lvlHit[l]) begin
        winValid  = 1'b1;
        winVector = lowestIdx(lvlHit[l]);
        winLevel  = PRIO_W'(l);
      end
    end
  end

  // read-back
  always_comb begin
    prioPack = '0;
    for (int i = 0; i < NUM_SRC; i++)
      prioPack[i / PER_WORD][(i % PER_WORD)*PRIO_W +: PRIO_W] = prioReg[i];
  end

  always_comb begin
    int a;
    a        = int'(regAddr);
    regRdata = '0;
    if (a == ADDR_EN)
      regRdata = DATA_W'(enReg);
    else if (a == ADDR_PEND)
      regRdata = DATA_W'(pendReg);
    else if (a == ADDR_MASK)
      regRdata = DATA_W'({maskOn, maskLvl});
    else if (a >= ADDR_PRIO0 && a < ADDR_PRIO0 + PRIO_WORDS)
      regRdata = prioPack[a - ADDR_PRIO0];
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  localparam int VEC_W      = $clog2(NUM_SRC),
  localparam int PRIO_WORDS = (NUM_SRC * PRIO_W + DATA_W - 1) / DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqLines,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               irqValid,
  output logic [VEC_W-1:0]   irqVector,
  output logic [PRIO_W-1:0]  irqLevel,
  input  logic               ackStrobe,
  input  logic               eosStrobe
);

  ctlStrobe_t        strobe;
  logic              actValid;
  logic [PRIO_W-1:0] actLevel;
  logic              nestFull;

  prio_irq_ctl #(
    .ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .PRIO_WORDS(PRIO_WORDS)
  ) uCtl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .ackStrobe(ackStrobe), .eosStrobe(eosStrobe),
    .winValid(irqValid), .winLevel(irqLevel),
    .strobe(strobe), .actValid(actValid), .actLevel(actLevel),
    .nestFull(nestFull)
  );

  prio_irq_dp #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .VEC_W(VEC_W), .PRIO_WORDS(PRIO_WORDS)
  ) uDp (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .regAddr(regAddr),
    .regWdata(regWdata), .strobe(strobe), .actValid(actValid),
    .actLevel(actLevel), .nestFull(nestFull), .regRdata(regRdata),
    .winValid(irqValid), .winVector(irqVector), .winLevel(irqLevel)
  );

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module prio_irq_ctrl_chk #(
  parameter int PRIO_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              irqValid,
  input logic [PRIO_W-1:0] irqLevel,
  input logic              ackStrobe,
  input logic              eosStrobe,
  input logic              actValid,
  input logic [PRIO_W-1:0] actLevel,
  input logic              nestFull
);

  assert_beats_active_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && actValid) |-> (irqLevel < actLevel));

  assert_full_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    nestFull |-> !irqValid);

  assert_ack_enters_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && irqValid) |=> (actValid && actLevel == $past(irqLevel)));

  assert_service_from_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(actValid) |-> $past(ackStrobe && irqValid));

  assert_eos_restore_R8: assert property (@(posedge clk) disable iff (!rstN)
    (eosStrobe && actValid && !(ackStrobe && irqValid)) |=> (actValid == $past(nestFull)));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.PRIO_W(PRIO_W)) uChk (
  .clk(clk), .rstN(rstN), .irqValid(irqValid), .irqLevel(irqLevel),
  .ackStrobe(ackStrobe), .eosStrobe(eosStrobe), .actValid(actValid),
  .actLevel(actLevel), .nestFull(nestFull)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] irqLines;
  logic        regWe;
  logic [2:0]  regAddr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic        irqValid;
  logic [4:0]  irqVector;
  logic [1:0]  irqLevel;
  logic        ackStrobe, eosStrobe;

  always #10 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irqValid(irqValid), .irqVector(irqVector), .irqLevel(irqLevel),
    .ackStrobe(ackStrobe), .eosStrobe(eosStrobe)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] curLines;

  // model state, from the requirements
  logic [31:0] mEn, mPend, mPrev;
  logic [1:0]  mPrio [32];
  logic        mMaskOn, mActV, mSavV;
  logic [1:0]  mMaskLvl, mActL, mSavL;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void modelWin(output logic v, output logic [4:0] vec, output logic [1:0] lvl);
    v = 1'b0; vec = '0; lvl = '0;
    for (int l = 0; l < 4 && !v; l++)
      for (int i = 0; i < 32 && !v; i++)
        if (mEn[i] && mPend[i] && mPrio[i] == 2'(l) &&
            (!mMaskOn || mPrio[i] < mMaskLvl) &&
            (!mActV || mPrio[i] < mActL) && !(mActV && mSavV)) begin
          v = 1'b1; vec = 5'(i); lvl = 2'(l);
        end
  endfunction

  function automatic logic [31:0] modelRead(logic [2:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      3'd0: r = mEn;
      3'd1: r = mPend;
      3'd2: r = {29'b0, mMaskOn, mMaskLvl};
      3'd3: for (int i = 0; i < 16; i++) r[2*i +: 2] = mPrio[i];
      3'd4: for (int i = 0; i < 16; i++) r[2*i +: 2] = mPrio[16+i];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic modelReset();
    mEn = '0; mPend = '0; mPrev = '0; mMaskOn = 0; mMaskLvl = 0;
    mActV = 0; mActL = 0; mSavV = 0; mSavL = 0;
    for (int i = 0; i < 32; i++) mPrio[i] = '0;
  endtask

  // one cycle: drive, check current outputs against model, advance model
  task automatic step(string tag, logic [31:0] lines, logic we, logic [2:0] a,
                      logic [31:0] wd, logic ack, logic eos);
    logic v; logic [4:0] vec; logic [1:0] lvl; logic ackOk;
    @(negedge clk);
    curLines = lines; irqLines = lines; regWe = we; regAddr = a;
    regWdata = wd; ackStrobe = ack; eosStrobe = eos;
    #1;
    modelWin(v, vec, lvl);
    check({tag, " valid"}, 32'(irqValid), 32'(v));
    if (v) begin
      check({tag, " vector"}, 32'(irqVector), 32'(vec));
      check({tag, " level"}, 32'(irqLevel), 32'(lvl));
    end
    check({tag, " read"}, regRdata, modelRead(a));
    ackOk = ack && v;
    if (ackOk) mPend[vec] = 1'b0;
    mPend = mPend | (lines & ~mPrev);
    mPrev = lines;
    if (we && a == 3'd1) mPend = mPend | wd;
    if (ackOk && eos && mActV) mActL = lvl;
    else if (ackOk) begin
      if (mActV) begin mSavV = 1; mSavL = mActL; end
      mActV = 1; mActL = lvl;
    end else if (eos && mActV) begin
      mActV = mSavV; mActL = mSavL; mSavV = 0; mSavL = 0;
    end
    if (we) begin
      case (a)
        3'd0: mEn = wd;
        3'd2: begin mMaskOn = wd[2]; mMaskLvl = wd[1:0]; end
        3'd3: for (int i = 0; i < 16; i++) mPrio[i] = wd[2*i +: 2];
        3'd4: for (int i = 0; i < 16; i++) mPrio[16+i] = wd[2*i +: 2];
        default: ;
      endcase
    end
    @(posedge clk); #1;
    regWe = 0; ackStrobe = 0; eosStrobe = 0;
  endtask

  task automatic expectWin(string tag, logic v, logic [4:0] vec);
    @(negedge clk); #1;
    check({tag, " valid"}, 32'(irqValid), 32'(v));
    if (v) check({tag, " vector"}, 32'(irqVector), 32'(vec));
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] l39;
    void'($urandom(32'd4242));
    rstN = 0; irqLines = '0; regWe = 0; regAddr = '0; regWdata = '0;
    ackStrobe = 0; eosStrobe = 0; curLines = '0;
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R9 reset state, R10 unmapped reads
    expectWin("R9 idle", 0, 0);
    for (int a = 0; a < 8; a++) step("R9 R10 reset read", '0, 0, 3'(a), '0, 0, 0);

    // R10 levels: src3=2, src5=1, src9=1, src20 stays 0
    step("R10 prio write", '0, 1, 3'd3, (32'd2 << 6) | (32'd1 << 10) | (32'd1 << 18), 0, 0);
    step("R10 enable write", '0, 1, 3'd0, 32'hFFFF_FFFF, 0, 3'd3 == 3'd3 ? 1'b0 : 1'b0);
    step("R10 readback", '0, 0, 3'd3, '0, 0, 0);

    // R1 R4 tie on level 1 -> lowest index 5
    l39 = (32'd1 << 3) | (32'd1 << 5) | (32'd1 << 9);
    step("R1 rise", l39, 0, 3'd1, '0, 0, 0);
    expectWin("R4 tie", 1, 5);
    step("R3 ack", l39, 0, 3'd1, '0, 1, 0);
    expectWin("R6 equal blocked", 0, 0);
    step("R2 sw set", l39, 1, 3'd1, 32'd1 << 20, 0, 0);
    expectWin("R2 R6 preempt", 1, 20);
    step("R7 second ack", l39, 0, 3'd1, '0, 1, 0);
    expectWin("R7 full", 0, 0);
    step("R7 ack ignored", l39, 0, 3'd1, '0, 1, 0);
    step("R8 eos pop", l39, 0, 3'd1, '0, 0, 1);
    expectWin("R8 restored", 0, 0);
    step("R8 eos idle", l39, 0, 3'd1, '0, 0, 1);
    expectWin("R8 R1 no re-arm", 1, 9);
    step("R8 eos ignored", l39, 0, 3'd1, '0, 0, 1);

    // R5 threshold
    step("R5 mask on 1", l39, 1, 3'd2, 32'h5, 0, 0);
    expectWin("R5 masked", 0, 0);
    step("R5 mask on 3", l39, 1, 3'd2, 32'h7, 0, 0);
    expectWin("R5 pass", 1, 9);

    // R3 ack and new rise on the same line in one cycle
    step("R3 drop", l39 & ~(32'd1 << 9), 0, 3'd1, '0, 0, 0);
    step("R3 collide", l39, 0, 3'd1, '0, 1, 0);
    step("R3 pend kept", l39, 0, 3'd1, '0, 0, 0);
    // R8 eos together with ack
    step("R8 open", l39, 1, 3'd1, 32'd1 << 20, 0, 0);
    step("R8 eos+ack", l39, 0, 3'd1, '0, 1, 1);
    step("R8 after", l39, 0, 3'd2, '0, 0, 1);
    step("R8 after2", l39, 0, 3'd1, '0, 0, 1);

    // random traffic (R4 main arbitration)
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] nl;
      nl = curLines ^ ($urandom & $urandom & $urandom);
      step("R4 random", nl, ($urandom % 5) == 0, 3'($urandom % 6), $urandom,
           ($urandom % 3) == 0, ($urandom % 4) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule